// File: doc/BRIEF.md
# Configuration Cycle Routing Decoder

The block keeps the host's 32-bit configuration address word and decides where each configuration data access goes. The word holds an enable flag, a bus number, a device number, a function number and a register number. When the host presents a configuration data request, the block decodes the stored word against a secondary and a subordinate bus number supplied from outside. It then sends the access to one of these destinations: an internal device, a type 0 or type 1 cycle on the PCI Express port, or a type 0 or type 1 cycle on the downstream legacy link. An access can also be dropped, and a dropped access completes with all-ones read data and no cycle downstream.

The decision comes out one clock after the request is accepted, through a valid/ready handshake. It carries a one-hot target code and the fields each target needs. PCI Express targets get three header bytes. Legacy-link and internal targets get a 24-bit packed address. Building packets, host bus timing and the data payload are left to neighbouring logic.

Top module: `cfg_route_dec`

## Requirements
- R1: After reset the address word reads as zero. A write stores bit 31 (enable), bits 23:16 (bus), 15:11 (device), 10:8 (function) and 7:2 (register). Bits 30:24 and 1:0 are discarded and read back as zero from the clock after the write.
- R2: With the enable bit clear, an accepted request completes with target code bit 5 (drop) alone set and `drop_rdata` equal to all ones.
- R3: Bus 0 with device 0, 1 or 2 and function 0 or 1 routes to target bit 0 (internal).
- R4: Bus 0 with device 0, 1 or 2 and a function above 1 is dropped: target bit 5 and all-ones `drop_rdata`. Header bytes and link address stay zero.
- R5: Bus 0 with a device above 2 routes to target bit 3 (legacy link, type 0).
- R6: A nonzero bus equal to the secondary bus number routes to target bit 1 (PCI Express, type 0).
- R7: A bus above the secondary number and no greater than the subordinate number routes to target bit 2 (PCI Express, type 1).
- R8: A nonzero bus outside the secondary-to-subordinate range routes to target bit 4 (legacy link, type 1). When secondary exceeds subordinate, only an exact match to secondary reaches PCI Express.
- R9: For PCI Express targets, `hdr_b8` carries the bus, `hdr_b6` carries {device, function}, and `hdr_b7` carries {register, 2'b00}. For every other target the three bytes are zero.
- R10: For legacy-link and internal targets, `link_addr` carries the bus in bits 23:16, the device in 15:11, the function in 10:8 and the register in 7:2, with bits 1:0 zero. For every other target it is zero.
- R11: A request accepted on a clock edge (`req_valid` and `req_ready`) shows `rsp_valid` from that edge on. While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and `req_ready` is low.
- R12: A request accepted in the same cycle as a register write is decoded from the word stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the address word |
| reg_wr_data | input | 32 | Address word to write |
| reg_rd_data | output | 32 | Stored address word, reserved bits zero |
| sec_bus | input | 8 | Secondary bus number |
| sub_bus | input | 8 | Subordinate bus number |
| req_valid | input | 1 | Configuration data access request |
| req_ready | output | 1 | Request can be accepted this cycle |
| rsp_valid | output | 1 | Routing decision available |
| rsp_ready | input | 1 | Consumer takes the decision |
| rsp_target | output | 6 | One-hot target code |
| hdr_b6 | output | 8 | PCI Express header byte 6 |
| hdr_b7 | output | 8 | PCI Express header byte 7 |
| hdr_b8 | output | 8 | PCI Express header byte 8 |
| link_addr | output | 24 | Packed address for legacy link or internal device |
| drop_rdata | output | 32 | All ones on a dropped access, else zero |

## Verification
A write shows on `reg_rd_data` one clock later. A request accepted at one edge shows its decision on the response outputs from that same edge on. The bench therefore drives the inputs at the falling edge and samples at the next falling edge after the edge that registers them. Stall cases keep `rsp_ready` low for several cycles and sample at each falling edge, to confirm the decision holds and `req_ready` stays low. The same-cycle case drives the write and the request together and reads both results at the next falling edge.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

    localparam int WORD_W  = 32;
    localparam int BUS_W   = 8;
    localparam int DEV_W   = 5;
    localparam int FUNC_W  = 3;
    localparam int REGN_W  = 6;
    localparam int LADDR_W = BUS_W + DEV_W + FUNC_W + REGN_W + 2;

    // one-hot target bit positions
    localparam int T_INT   = 0;
    localparam int T_PCIE0 = 1;
    localparam int T_PCIE1 = 2;
    localparam int T_LINK0 = 3;
    localparam int T_LINK1 = 4;
    localparam int T_DROP  = 5;
    localparam int NUM_TGT = 6;

    typedef struct packed {
        logic              en;
        logic [BUS_W-1:0]  bus;
        logic [DEV_W-1:0]  dev;
        logic [FUNC_W-1:0] func;
        logic [REGN_W-1:0] regn;
    } cfg_word_t;

    typedef struct packed {
        logic [NUM_TGT-1:0] tgt;
        logic [7:0]         b6;
        logic [7:0]         b7;
        logic [7:0]         b8;
        logic [LADDR_W-1:0] laddr;
        logic [WORD_W-1:0]  drop_data;
    } route_t;

    function automatic cfg_word_t unpack_word(input logic [WORD_W-1:0] w);
        cfg_word_t c;
        c.en   = w[31];
        c.bus  = w[23:16];
        c.dev  = w[15:11];
        c.func = w[10:8];
        c.regn = w[7:2];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input cfg_word_t c);
        return {c.en, 7'b0, c.bus, c.dev, c.func, c.regn, 2'b00};
    endfunction

endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
    import cfg_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output cfg_word_t         word_q,
    output logic [WORD_W-1:0] rd_data
);
    logic unused_rsvd;
    assign unused_rsvd = ^{wr_data[30:24], wr_data[1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (wr_en) begin
            word_q <= unpack_word(wr_data);
        end
    end

    assign rd_data = pack_word(word_q);
endmodule

// File: rtl/cfg_route_logic.sv
module cfg_route_logic
    import cfg_route_pkg::*;
#(
    parameter int INT_DEV_MAX  = 2,
    parameter int INT_FUNC_MAX = 1
) (
    input  cfg_word_t        word,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    output route_t           route
);
    localparam logic [DEV_W-1:0]  DEV_LIM  = DEV_W'(INT_DEV_MAX);
    localparam logic [FUNC_W-1:0] FUNC_LIM = FUNC_W'(INT_FUNC_MAX);

    logic [NUM_TGT-1:0] tgt;
    logic               is_pcie;
    logic               is_addr;

    always_comb begin
        tgt = '0;
        if (!word.en) begin
            tgt[T_DROP] = 1'b1;
        end else if (word.bus == '0) begin
            if (word.dev <= DEV_LIM) begin
                if (word.func <= FUNC_LIM) tgt[T_INT]  = 1'b1;
                else                       tgt[T_DROP] = 1'b1;
            end else begin
                tgt[T_LINK0] = 1'b1;
            end
        end else if (word.bus == sec_bus) begin
            tgt[T_PCIE0] = 1'b1;
        end else if (word.bus > sec_bus && word.bus <= sub_bus) begin
            tgt[T_PCIE1] = 1'b1;
        end else begin
            tgt[T_LINK1] = 1'b1;
        end
    end

    assign is_pcie = tgt[T_PCIE0] | tgt[T_PCIE1];
    assign is_addr = tgt[T_LINK0] | tgt[T_LINK1] | tgt[T_INT];

    always_comb begin
        route     = '0;
        route.tgt = tgt;
        if (is_pcie) begin
            route.b6 = {word.dev, word.func};
            route.b7 = {word.regn, 2'b00};
            route.b8 = word.bus;
        end
        if (is_addr) begin
            route.laddr = {word.bus, word.dev, word.func, word.regn, 2'b00};
        end
        if (tgt[T_DROP]) begin
            route.drop_data = '1;
        end
    end
endmodule

// File: rtl/cfg_dispatch.sv
module cfg_dispatch
    import cfg_route_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    output logic   req_ready,
    input  route_t route_in,
    output logic   rsp_valid,
    input  logic   rsp_ready,
    output route_t route_q
);
    assign req_ready = !rsp_valid || rsp_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            route_q   <= '0;
        end else if (req_ready) begin
            rsp_valid <= req_valid;
            if (req_valid) route_q <= route_in;
        end
    end
endmodule

// File: rtl/cfg_route_dec.sv
module cfg_route_dec
    import cfg_route_pkg::*;
#(
    parameter int INT_DEV_MAX  = 2,
    parameter int INT_FUNC_MAX = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr_en,
    input  logic [WORD_W-1:0]   reg_wr_data,
    output logic [WORD_W-1:0]   reg_rd_data,
    input  logic [BUS_W-1:0]    sec_bus,
    input  logic [BUS_W-1:0]    sub_bus,
    input  logic                req_valid,
    output logic                req_ready,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic [NUM_TGT-1:0]  rsp_target,
    output logic [7:0]          hdr_b6,
    output logic [7:0]          hdr_b7,
    output logic [7:0]          hdr_b8,
    output logic [LADDR_W-1:0]  link_addr,
    output logic [WORD_W-1:0]   drop_rdata
);
    cfg_word_t word_q;
    route_t    route_d;
    route_t    route_q;

    cfg_addr_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .word_q  (word_q),
        .rd_data (reg_rd_data)
    );

    cfg_route_logic #(
        .INT_DEV_MAX  (INT_DEV_MAX),
        .INT_FUNC_MAX (INT_FUNC_MAX)
    ) u_logic (
        .word    (word_q),
        .sec_bus (sec_bus),
        .sub_bus (sub_bus),
        .route   (route_d)
    );

    cfg_dispatch u_disp (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .route_in  (route_d),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .route_q   (route_q)
    );

    assign rsp_target = route_q.tgt;
    assign hdr_b6     = route_q.b6;
    assign hdr_b7     = route_q.b7;
    assign hdr_b8     = route_q.b8;
    assign link_addr  = route_q.laddr;
    assign drop_rdata = route_q.drop_data;
endmodule

// File: rtl/cfg_route_chk.sv
module cfg_route_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr_en,
    input logic [31:0] reg_wr_data,
    input logic [31:0] reg_rd_data,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [5:0]  rsp_target,
    input logic [7:0]  hdr_b6,
    input logic [7:0]  hdr_b7,
    input logic [7:0]  hdr_b8,
    input logic [23:0] link_addr,
    input logic [31:0] drop_rdata
);
    // R1: a write shows up masked on the next cycle
    a_r1_write_readback: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> reg_rd_data == ($past(reg_wr_data) & 32'h80FF_FFFC));

    // R11: an accepted request yields a response next cycle
    a_r11_accept_to_rsp: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    // R11: a stalled response holds steady
    a_r11_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_target)
            && $stable(link_addr) && $stable(hdr_b6) && $stable(hdr_b8));

    // R2: the target code is one-hot whenever valid
    a_r2_onehot_target: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones(rsp_target) == 1);

    // R4: a drop carries all-ones data and no fields
    a_r4_drop_fields: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_target[5]) |-> (drop_rdata == 32'hFFFF_FFFF
            && link_addr == '0 && {hdr_b6, hdr_b7, hdr_b8} == '0));

    // R9: header bytes only for PCI Express targets
    a_r9_hdr_only_pcie: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !(rsp_target[1] || rsp_target[2])) |-> {hdr_b6, hdr_b7, hdr_b8} == '0);

    // R10: link address only for link or internal targets
    a_r10_laddr_targets: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !(rsp_target[0] || rsp_target[3] || rsp_target[4])) |-> link_addr == '0);
endmodule

bind cfg_route_dec cfg_route_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_target  (rsp_target),
    .hdr_b6      (hdr_b6),
    .hdr_b7      (hdr_b7),
    .hdr_b8      (hdr_b8),
    .link_addr   (link_addr),
    .drop_rdata  (drop_rdata)
);

// File: tb/cfg_route_dec_tb_top.sv
module cfg_route_dec_tb_top;

    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  sec;
        logic [7:0]  sub;
        logic [5:0]  tgt;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 14;
    // target bits: 0 internal, 1 pcie t0, 2 pcie t1, 3 link t0, 4 link t1, 5 drop
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 8'd3, 8'd7,   6'b100000, 8'd2},  // R2 disabled
        '{32'h8000_0000, 8'd3, 8'd7,   6'b000001, 8'd3},  // R3 dev0 f0
        '{32'h8000_0904, 8'd3, 8'd7,   6'b000001, 8'd3},  // R3 dev1 f1
        '{32'h8000_1200, 8'd3, 8'd7,   6'b100000, 8'd4},  // R4 dev2 f2
        '{32'h8000_0A00, 8'd3, 8'd7,   6'b100000, 8'd4},  // R4 dev1 f2
        '{32'h8000_1800, 8'd3, 8'd7,   6'b001000, 8'd5},  // R5 dev3
        '{32'h8003_28FC, 8'd3, 8'd7,   6'b000010, 8'd6},  // R6 bus==sec
        '{32'h8007_0000, 8'd3, 8'd7,   6'b000100, 8'd7},  // R7 bus==sub
        '{32'h8008_0000, 8'd3, 8'd7,   6'b010000, 8'd8},  // R8 above sub
        '{32'h8002_0000, 8'd3, 8'd7,   6'b010000, 8'd8},  // R8 below sec
        '{32'h8005_0000, 8'd5, 8'd2,   6'b000010, 8'd8},  // R8 sec>sub exact
        '{32'h8006_0000, 8'd5, 8'd2,   6'b010000, 8'd8},  // R8 sec>sub miss
        '{32'h80FF_FFFF, 8'd1, 8'd255, 6'b000100, 8'd9},  // R9 full fields
        '{32'h7F03_0003, 8'd3, 8'd7,   6'b100000, 8'd1}   // R1 reserved bits
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [31:0] reg_wr_data;
    logic [31:0] reg_rd_data;
    logic [7:0]  sec_bus;
    logic [7:0]  sub_bus;
    logic        req_valid;
    logic        req_ready;
    logic        rsp_valid;
    logic        rsp_ready;
    logic [5:0]  rsp_target;
    logic [7:0]  hdr_b6;
    logic [7:0]  hdr_b7;
    logic [7:0]  hdr_b8;
    logic [23:0] link_addr;
    logic [31:0] drop_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cfg_route_dec dut_i (
        .clk (clk), .rst (rst),
        .reg_wr_en (reg_wr_en), .reg_wr_data (reg_wr_data), .reg_rd_data (reg_rd_data),
        .sec_bus (sec_bus), .sub_bus (sub_bus),
        .req_valid (req_valid), .req_ready (req_ready),
        .rsp_valid (rsp_valid), .rsp_ready (rsp_ready),
        .rsp_target (rsp_target), .hdr_b6 (hdr_b6), .hdr_b7 (hdr_b7), .hdr_b8 (hdr_b8),
        .link_addr (link_addr), .drop_rdata (drop_rdata)
    );

    task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic check_rsp(input logic [31:0] a, input logic [5:0] t, input string rq);
        logic [7:0]  e6, e7, e8;
        logic [23:0] ela;
        logic [31:0] ed;
        e6 = 8'h0; e7 = 8'h0; e8 = 8'h0; ela = 24'h0; ed = 32'h0;
        if (t[1] || t[2]) begin            // R9 packing
            e6 = a[15:8]; e7 = a[7:0] & 8'hFC; e8 = a[23:16];
        end
        if (t[0] || t[3] || t[4]) ela = a[23:0] & 24'hFF_FFFC;  // R10 packing
        if (t[5]) ed = 32'hFFFF_FFFF;
        check(rsp_valid == 1'b1, {rq, " valid"}, 64'(rsp_valid), 64'd1);
        check(rsp_target == t, {rq, " target"}, 64'(rsp_target), 64'(t));
        check({hdr_b6, hdr_b7, hdr_b8} == {e6, e7, e8}, {rq, " R9 header"},
              64'({hdr_b6, hdr_b7, hdr_b8}), 64'({e6, e7, e8}));
        check(link_addr == ela, {rq, " R10 link_addr"}, 64'(link_addr), 64'(ela));
        check(drop_rdata == ed, {rq, " drop data"}, 64'(drop_rdata), 64'(ed));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; reg_wr_en = 1'b0; reg_wr_data = '0; sec_bus = '0; sub_bus = '0;
        req_valid = 1'b0; rsp_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 / R11 reset state
        check(reg_rd_data == 32'h0, "R1 reset word", 64'(reg_rd_data), 64'd0);
        check(rsp_valid == 1'b0, "R11 reset valid", 64'(rsp_valid), 64'd0);
        check(req_ready == 1'b1, "R11 reset ready", 64'(req_ready), 64'd1);

        for (int i = 0; i < NV; i++) begin
            reg_wr_en = 1'b1; reg_wr_data = VECS[i].addr;
            sec_bus = VECS[i].sec; sub_bus = VECS[i].sub;
            @(negedge clk);
            reg_wr_en = 1'b0;
            check(reg_rd_data == (VECS[i].addr & 32'h80FF_FFFC), "R1 readback",
                  64'(reg_rd_data), 64'(VECS[i].addr & 32'h80FF_FFFC));
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check_rsp(VECS[i].addr, VECS[i].tgt, $sformatf("R%0d vec%0d", VECS[i].rq, i));
            @(negedge clk);
            check(rsp_valid == 1'b0, "R11 drains", 64'(rsp_valid), 64'd0);
        end

        // R11 back-pressure: response held, later request waits
        sec_bus = 8'd3; sub_bus = 8'd7;
        reg_wr_en = 1'b1; reg_wr_data = 32'h8000_1800;
        @(negedge clk);
        reg_wr_en = 1'b0; rsp_ready = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_data = 32'h8000_0000;
        @(negedge clk);
        reg_wr_en = 1'b0;
        for (int k = 0; k < 2; k++) begin
            check(req_ready == 1'b0, "R11 stall ready", 64'(req_ready), 64'd0);
            check_rsp(32'h8000_1800, 6'b001000, "R11 stall hold");
            @(negedge clk);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(32'h8000_0000, 6'b000001, "R11 next after release");
        @(negedge clk);
        check(rsp_valid == 1'b0, "R11 idle after release", 64'(rsp_valid), 64'd0);

        // R12: request and write in the same cycle
        reg_wr_en = 1'b1; reg_wr_data = 32'h8000_1800;
        @(negedge clk);
        reg_wr_data = 32'h8003_0000; req_valid = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; req_valid = 1'b0;
        check_rsp(32'h8000_1800, 6'b001000, "R12 old word");
        check(reg_rd_data == 32'h8003_0000, "R12 new word stored", 64'(reg_rd_data), 64'h8003_0000);
        @(negedge clk);

        finish_run();
    end
endmodule